// File: doc/BRIEF.md
# Preloadable Interval Timer with Sticky Interrupt

This block is an 8-bit up-counting interval timer that sits on the write side of a small 8-bit processor bus. A prescaler divides the system clock by four to make a one-microsecond count enable. The counter starts from a value that software presets. Each time the count advances into its all-ones value with the interrupt unmasked, a sticky flag is latched. That flag drives a level interrupt request to the processor.

Software programs the block with three write-only registers: a preset value, a control byte and an acknowledge byte. The control byte holds an active-low run bit and an active-high interrupt unmask bit. The flag cannot be read back. It is dropped only by a write-one strobe to the acknowledge register. The interval from starting the timer to the request is therefore set by the preset, in steps of one microsecond, from 1 to 256 microseconds.

Top module: `bt_base_timer`

## Requirements
- R1: While running, the count rises by one every 4 clocks. After the write that starts the timer or reloads it with preset P, irq rises on the clock edge 4*(255-P) edges later for P below FFh, and 1024 edges later for P = FFh.
- R2: After reset the timer is stopped, the count and preset are 00h, the interrupt is masked, the flag is clear and irq is 0. Starting the timer without a preset write gives the request 1020 edges later.
- R3: Registers are write-only and decoded on wr_addr. C0h is the preset. C1h is control: bit 0 is run_n, where 0 runs and 1 stops, and bit 1 is the interrupt unmask, where 1 unmasks. C2h is acknowledge: bit 0 = 1 clears the flag. A write to any other address has no effect.
- R4: The run bit acts as a level. Only the change from stopped to running reloads the count from the preset and restarts the prescaler phase. Writing run_n = 0 again while the timer runs changes nothing.
- R5: While run_n is 1 the count holds and no request is raised.
- R6: The flag is set only when the count advances into FFh while the interrupt is unmasked. With the interrupt masked, irq stays 0.
- R7: After FFh the count wraps to 00h and keeps going, so the next request follows 1024 edges after the previous one.
- R8: Once set, the flag stays set until an acknowledge write with bit 0 = 1. An acknowledge write with bit 0 = 0 leaves it set.
- R9: When a set and an acknowledge fall on the same edge, the flag stays set.
- R10: A preset write while the timer runs loads the count on that edge and restarts the prescaler phase.
- R11: irq is the registered flag itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four times the count rate |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | 8 | Bus write data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench measures the edge on which irq rises after each start or reload. A mistake of one in the prescaler phase or in the terminal compare shows up as a count that is off by one tick or by one clock. A design that treated the run bit as an edge trigger would restart on a repeated run write and raise its request late. It also checks that an acknowledge landing on the set edge leaves the request asserted, where a clear-priority design would lose the interrupt. Finally, it checks that a mid-run preset write moves the next request to the new interval, where a design that kept the old prescaler phase would fire up to three clocks early.

// File: rtl/bt_pkg.sv
package bt_pkg;
    // Decoded write strobes shared between the register file and the datapath.
    typedef struct packed {
        logic preset_we;
        logic ctrl_we;
        logic ack_we;
    } bt_wr_s;
endpackage

// File: rtl/bt_regs.sv
module bt_regs
    import bt_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 8,
    parameter logic [ADDR_W-1:0] PRESET_ADDR = 8'hC0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'hC1,
    parameter logic [ADDR_W-1:0] ACK_ADDR    = 8'hC2,
    parameter int RUNN_BIT    = 0,
    parameter int UNMASK_BIT  = 1,
    parameter int ACK_BIT     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              run_o,
    output logic              unmask_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              ack_o
);
    typedef struct packed {
        logic             run;
        logic             unmask;
        logic [CNT_W-1:0] preset;
    } regs_s;

    regs_s  st_d, st_q;
    bt_wr_s wr;
    logic   start;

    always_comb begin
        wr.preset_we = wr_en && (wr_addr == PRESET_ADDR);
        wr.ctrl_we   = wr_en && (wr_addr == CTRL_ADDR);
        wr.ack_we    = wr_en && (wr_addr == ACK_ADDR);

        st_d  = st_q;
        start = wr.ctrl_we && !wr_data[RUNN_BIT] && !st_q.run;
        if (wr.preset_we) st_d.preset = wr_data[CNT_W-1:0];
        if (wr.ctrl_we) begin
            st_d.run    = !wr_data[RUNN_BIT];
            st_d.unmask = wr_data[UNMASK_BIT];
        end

        load_o     = wr.preset_we || start;
        load_val_o = wr.preset_we ? wr_data[CNT_W-1:0] : st_q.preset;
        ack_o      = wr.ack_we && wr_data[ACK_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o    = st_q.run;
    assign unmask_o = st_q.unmask;

    // A stopped timer that becomes running must have reloaded on that edge.
    assert_start_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && wr_en && wr_addr == CTRL_ADDR && !wr_data[RUNN_BIT]) |-> load_o);
endmodule

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_s;

    pre_s st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = run_i && !restart_i && (st_q.phase == LAST);
        if (restart_i || !run_i)    st_d.phase = '0;
        else if (st_q.phase == LAST) st_d.phase = '0;
        else                         st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_restart_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.phase == '0));
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] BEFORE_TOP = {{(CNT_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_s;

    cnt_s st_d, st_q;

    always_comb begin
        st_d  = st_q;
        hit_o = tick_i && !load_i && (st_q.cnt == BEFORE_TOP);
        if (load_i)      st_d.cnt = load_val_i;
        else if (tick_i) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_step_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i) |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(st_q.cnt));
    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == $past(load_val_i)));
endmodule

// File: rtl/bt_irqflag.sv
module bt_irqflag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic unmask_i,
    input  logic ack_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_s;

    flag_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit_i && unmask_i) st_d.flag = 1'b1;
        else if (ack_i)        st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !ack_i) |=> flag_o);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && unmask_i) |=> flag_o);
    assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !(hit_i && unmask_i)) |=> !flag_o);
endmodule

// File: rtl/bt_base_timer.sv
module bt_base_timer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int DIV    = 4,
    parameter logic [ADDR_W-1:0] PRESET_ADDR = 8'hC0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'hC1,
    parameter logic [ADDR_W-1:0] ACK_ADDR    = 8'hC2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq
);
    logic             run, unmask, load, ack, tick, hit;
    logic [CNT_W-1:0] load_val;

    bt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .PRESET_ADDR(PRESET_ADDR), .CTRL_ADDR(CTRL_ADDR), .ACK_ADDR(ACK_ADDR),
        .RUNN_BIT(0), .UNMASK_BIT(1), .ACK_BIT(0)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run_o(run), .unmask_o(unmask), .load_o(load),
        .load_val_o(load_val), .ack_o(ack)
    );

    bt_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(load), .tick_o(tick)
    );

    bt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load),
        .load_val_i(load_val), .hit_o(hit)
    );

    bt_irqflag u_flag (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .unmask_i(unmask),
        .ack_i(ack), .flag_o(irq)
    );

    assert_tick_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);
    assert_reset_quiet_R2: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

// File: tb/tb_bt_base_timer.sv
module tb_bt_base_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq;
    int         n_chk = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    bt_base_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq(irq)
    );

    // {preset, expected edges from start write to irq rise}
    localparam logic [23:0] VEC [6] = '{
        {8'hFE, 16'd4},   {8'hF0, 16'd60},  {8'h80, 16'd508},
        {8'h01, 16'd1016}, {8'hFF, 16'd1024}, {8'h00, 16'd1020}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Caller is at a negedge; write is sampled on the next posedge.
    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count posedges after the last write until irq is seen high.
    task automatic measure(output int k);
        k = 0;
        while (k < 2000) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (irq) return;
        end
        k = -1;
    endtask

    task automatic quiet_for(input int cyc, input string req);
        int hi = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (irq) hi = 1;
        end
        chk(req, hi, 0);
    endtask

    initial begin
        #3000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 irq after reset", int'(irq), 0);

        // R2/R5: unmasked but stopped, nothing happens
        bus_wr(8'hC1, 8'h03);
        quiet_for(1100, "R5 stopped no irq");
        // R2: count and preset start at 00h
        bus_wr(8'hC1, 8'h02);
        measure(k);
        chk("R2 reset count 00", k, 1020);

        // R1/R3: vector table
        foreach (VEC[i]) begin
            bus_wr(8'hC1, 8'h03);
            bus_wr(8'hC2, 8'h01);
            chk("R8 ack clears", int'(irq), 0);
            bus_wr(8'hC0, VEC[i][23:16]);
            bus_wr(8'hC1, 8'h02);
            measure(k);
            chk("R1 interval", k, int'(VEC[i][15:0]));
        end

        // R8: ack with bit0=0 ignored, then R7 wrap interval
        bus_wr(8'hC1, 8'h03);
        bus_wr(8'hC2, 8'h01);
        bus_wr(8'hC0, 8'hFE);
        bus_wr(8'hC1, 8'h02);
        measure(k);
        chk("R1 preset FE", k, 4);
        bus_wr(8'hC2, 8'h00);
        chk("R8 ack bit0=0 keeps flag", int'(irq), 1);
        bus_wr(8'hC2, 8'h01);
        chk("R8 ack bit0=1 clears", int'(irq), 0);
        measure(k);
        chk("R7 wrap period", k, 1022);

        // R9: ack on the set edge
        bus_wr(8'hC1, 8'h03);
        bus_wr(8'hC2, 8'h01);
        bus_wr(8'hC1, 8'h02);
        repeat (3) @(negedge clk);
        bus_wr(8'hC2, 8'h01);
        chk("R9 set wins over ack", int'(irq), 1);
        @(negedge clk);
        chk("R11 irq holds flag", int'(irq), 1);

        // R4/R3: repeated run write and foreign addresses do not restart
        bus_wr(8'hC1, 8'h03);
        bus_wr(8'hC2, 8'h01);
        bus_wr(8'hC0, 8'h80);
        bus_wr(8'hC1, 8'h02);
        repeat (98) @(negedge clk);
        bus_wr(8'hC1, 8'h02);
        bus_wr(8'hC3, 8'h01);
        bus_wr(8'h40, 8'h00);
        measure(k);
        chk("R4 level run no restart", k + 98 + 3, 508);

        // R6: masked interrupt
        bus_wr(8'hC1, 8'h03);
        bus_wr(8'hC2, 8'h01);
        bus_wr(8'hC0, 8'hFE);
        bus_wr(8'hC1, 8'h00);
        quiet_for(40, "R6 masked no irq");

        // R5: stopping mid-count
        bus_wr(8'hC1, 8'h03);
        bus_wr(8'hC0, 8'h80);
        bus_wr(8'hC1, 8'h02);
        repeat (100) @(negedge clk);
        bus_wr(8'hC1, 8'h03);
        quiet_for(600, "R5 stop holds count");

        // R10: preset write while running
        bus_wr(8'hC0, 8'h00);
        bus_wr(8'hC1, 8'h02);
        repeat (201) @(negedge clk);
        bus_wr(8'hC0, 8'hF0);
        measure(k);
        chk("R10 running reload", k, 60);

        // R2: reset mid-operation
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R2 irq cleared by reset", int'(irq), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule